// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing front end of a 256-byte serial memory. It watches a two-wire serial bus (a clock line and a bidirectional data line) by oversampling both lines on the system clock. It detects START and STOP conditions and recognises its own 7-bit device address. It then acts as the slave of the transfer. In a write transfer it takes a one-byte word address and then any number of data bytes. It hands each data byte to an external write buffer as a single-cycle strobe with its target address.

In a read transfer it returns bytes from an external memory array, which it addresses through a read-address port. Three read forms are supported: a current-address read, a random read (a write transfer that carries only the word address, then a repeated START and a read), and a sequential read of any length. One address counter serves both reads and writes. Every accessed byte advances it by one, and it wraps from 255 back to 0.

The data line is driven open-drain. The output is an enable: when it is high the pad pulls the line low. While the write buffer reports that an internal write cycle is running, the block refuses its device address, so the master can poll for completion.

Top module: `i2c_mem_slave`

## Requirements
- R1: A device address byte is sent MSB first: seven address bits, then the direction bit (0 = write, 1 = read). If the seven bits equal the parameter DEV_ADDR, the slave acknowledges by pulling the data line low during the ninth clock. On a mismatch it gives no acknowledge, acknowledges no later byte, issues no write strobe and leaves its address counter untouched until the next START.
- R2: While wr_busy is high at the end of a matching device address byte, the slave does not acknowledge, and the transfer is ignored as in R1.
- R3: In a write transfer, the byte after the device address is loaded into the address counter and acknowledged. Each later data byte is acknowledged and produces a one-cycle wr_valid pulse, with wr_addr equal to the counter and wr_data equal to the byte. The counter then advances by one.
- R4: A random read returns the byte at the word address just sent. A random read is a write transfer holding only the word address, then a repeated START and the device address with the direction bit set to 1.
- R5: After reset the address counter is 0. A read with no word address returns the byte at the last accessed location plus one. This holds whether the last access was a read or a write.
- R6: The address counter wraps from 255 to 0 for both current-address and sequential reads.
- R7: In a read, every master acknowledge (data line low in the ninth clock) makes the slave advance the address and send the next byte, MSB first.
- R8: A master not-acknowledge (data line high in the ninth clock) ends the read. The slave then releases the data line and does not drive it again before a new START.
- R9: A START or STOP in the middle of a transfer aborts it. A partly received data byte is discarded without a write strobe. A word address that was already acknowledged stays in the counter.
- R10: The slave changes its data line drive only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are oversampled on it |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pull data line low when 1 (open-drain enable) |
| rd_addr | output | 8 | Address counter, used as memory read address |
| rd_data | input | 8 | Memory byte at rd_addr, valid within a few clocks |
| wr_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | 8 | Target address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| wr_busy | input | 1 | Write buffer is running an internal write cycle |

## Verification
A wrong address counter shows up at the latest on the first byte of the next current-address read. It also shows as a wr_addr off by some amount on the first strobe after it, so random transfers begin without a word address. These random transfers are mixed with explicit wrap cases at location 255. A bit counter or state that slips shows within one byte: an acknowledge is missing in the ninth clock, the data line is pulled low while the master reads, or a strobe is missing or extra. The bench counts the strobes after every write, after aborted transfers and after refused addresses.

// File: rtl/i2c_mem_pkg.sv
`timescale 1ns/1ps
package i2c_mem_pkg;
  typedef enum logic [3:0] {
    S_IDLE,   // off the bus, waiting for START
    S_DEV,    // shifting in device address byte
    S_DACK,   // ninth clock of device address
    S_WADR,   // shifting in word address
    S_WAACK,  // ack of word address
    S_WDAT,   // shifting in a data byte
    S_WDACK,  // ack of a data byte
    S_RDAT,   // shifting out a data byte
    S_RACK    // master ack/nack slot
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= {STAGES{1'b1}};
      sda_pipe <= {STAGES{1'b1}};
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edges with the clock line steady high
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_addr_ctr.sv
`timescale 1ns/1ps
module i2c_addr_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (inc)  addr <= addr + 1'b1;  // natural wrap at the top
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
`timescale 1ns/1ps
module i2c_slave_fsm
  import i2c_mem_pkg::*;
#(
  parameter int          AW       = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          wr_busy,
  input  logic [7:0]    rd_data,
  input  logic [AW-1:0] cur_addr,
  output logic          sda_oe,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          ctr_load,
  output logic [AW-1:0] ctr_val,
  output logic          ctr_inc,
  output slv_state_e    state
);
  localparam logic [3:0] BITS = 4'd8;

  logic [3:0] bcnt;
  logic [7:0] sh;
  logic       rw;
  logic       m_ack;
  logic       bus_evt;
  logic       byte_end;

  assign bus_evt  = start_det | stop_det;
  assign byte_end = scl_fall && (bcnt == BITS) && !bus_evt;

  assign ctr_load = (state == S_WADR) && byte_end;
  assign ctr_val  = AW'(sh);
  assign ctr_inc  = ((state == S_WDAT) || (state == S_RDAT)) && byte_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      bcnt     <= '0;
      sh       <= '0;
      rw       <= 1'b0;
      m_ack    <= 1'b0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_det) begin
        state  <= S_DEV;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: ;
          S_DEV, S_WADR, S_WDAT: begin
            if (scl_rise && bcnt < BITS) begin
              sh   <= {sh[6:0], sda_s};
              bcnt <= bcnt + 1'b1;
            end else if (byte_end) begin
              bcnt <= '0;
              if (state == S_DEV) begin
                if (sh[7:1] == DEV_ADDR && !wr_busy) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  state  <= S_DACK;
                end else begin
                  state  <= S_IDLE;
                end
              end else if (state == S_WADR) begin
                sda_oe <= 1'b1;
                state  <= S_WAACK;
              end else begin
                sda_oe   <= 1'b1;
                wr_valid <= 1'b1;
                wr_addr  <= cur_addr;
                wr_data  <= sh;
                state    <= S_WDACK;
              end
            end
          end
          S_DACK: begin
            if (scl_fall) begin
              if (rw) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                bcnt   <= '0;
                state  <= S_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_WADR;
              end
            end
          end
          S_WAACK, S_WDACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= S_WDAT;
            end
          end
          S_RDAT: begin
            if (scl_rise) begin
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall) begin
              if (bcnt == BITS) begin
                sda_oe <= 1'b0;
                state  <= S_RACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                bcnt   <= '0;
                state  <= S_RDAT;
              end else begin
                state  <= S_IDLE;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_slave.sv
`timescale 1ns/1ps
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         MEM_DEPTH   = 256,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(MEM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  input  logic          wr_busy
);
  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          ctr_load, ctr_inc;
  logic [AW-1:0] ctr_val;
  slv_state_e    fsm_state;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_addr_ctr #(.AW(AW)) ctr_i (
    .clk(clk), .rst(rst), .load(ctr_load), .load_val(ctr_val),
    .inc(ctr_inc), .addr(rd_addr)
  );

  i2c_slave_fsm #(.AW(AW), .DEV_ADDR(DEV_ADDR)) fsm_i (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .wr_busy(wr_busy), .rd_data(rd_data), .cur_addr(rd_addr),
    .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctr_load(ctr_load), .ctr_val(ctr_val),
    .ctr_inc(ctr_inc), .state(fsm_state)
  );
endmodule

// File: rtl/i2c_mem_slave_chk.sv
`timescale 1ns/1ps
module i2c_mem_slave_chk
  import i2c_mem_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_s,
  input logic          stop_det,
  input logic          sda_oe,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] rd_addr,
  input logic          wr_busy,
  input logic [3:0]    st
);
  // R2: an acknowledge of the device address never follows a busy write buffer
  p_busy_nack_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && st == S_DACK) |-> !$past(wr_busy));

  // R3: the counter sits one past every strobed write address
  p_wr_advance_r3: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> rd_addr == AW'(wr_addr + 1'b1));

  // R7, R6: finishing a sent byte advances the counter by one, wrapping
  p_rd_advance_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_RACK && $past(st) == S_RDAT) |-> rd_addr == AW'($past(rd_addr) + 1'b1));

  // R9: a STOP leaves the data line released
  p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R10: the drive changes only while the clock line is low
  p_sda_low_phase_r10: assert property (@(posedge clk) disable iff (rst)
    $changed(sda_oe) |-> !scl_s);
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .scl_s(scl_s), .stop_det(stop_det),
  .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .rd_addr(rd_addr), .wr_busy(wr_busy), .st(fsm_state)
);

// File: tb/i2c_mem_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_mem_slave_tb_top;
  localparam logic [6:0] DEV = 7'h50;

  logic       clk = 1'b0, rst = 1'b1, scl = 1'b1, m_sda = 1'b1, wr_busy = 1'b0;
  logic       sda_oe, wr_valid, sda_line, prev_oe;
  logic [7:0] rd_addr, wr_addr, wr_data, rd_data;
  logic [7:0] mem  [256];
  logic [7:0] emem [256];
  logic [7:0] eptr;
  int checks = 0, failures = 0, wr_cnt = 0, viol = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;
  assign rd_data  = mem[rd_addr];

  i2c_mem_slave #(.DEV_ADDR(DEV)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_busy(wr_busy)
  );

  // write buffer model and drive-phase monitor
  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      mem[wr_addr] = wr_data;
      wr_cnt++;
    end
    if (!rst && sda_oe !== prev_oe && scl) viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic q();
    repeat (8) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; q(); scl = 1'b1; q(); m_sda = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; q(); scl = 1'b1; q(); m_sda = 1'b1; q(); q();
  endtask

  task automatic wbit(input logic b);
    m_sda = b; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; q(); scl = 1'b1; q(); b = sda_line; q(); scl = 1'b0; q();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~mack);
  endtask

  task automatic do_write(input logic [7:0] a, input int n);
    logic ack;
    logic [7:0] d;
    int base;
    base = wr_cnt;
    i2c_start();
    wbyte({DEV, 1'b0}, ack); chk(ack, "R1 dev ack (write)", ack, 1);
    wbyte(a, ack);           chk(ack, "R3 word addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      wbyte(d, ack);         chk(ack, "R3 data ack", ack, 1);
      emem[8'(a + i)] = d;
    end
    i2c_stop();
    chk(wr_cnt - base == n, "R3 strobe count", wr_cnt - base, n);
    for (int i = 0; i < n; i++)
      chk(mem[8'(a + i)] == emem[8'(a + i)], "R3 written byte",
          mem[8'(a + i)], emem[8'(a + i)]);
    eptr = 8'(a + n);
  endtask

  task automatic read_body(input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, d);
      chk(d == emem[eptr], tag, d, emem[eptr]);
      eptr = eptr + 8'd1;
    end
  endtask

  task automatic do_rand_read(input logic [7:0] a, input int n);
    logic ack;
    i2c_start();
    wbyte({DEV, 1'b0}, ack); chk(ack, "R4 dev ack (dummy write)", ack, 1);
    wbyte(a, ack);           chk(ack, "R4 word addr ack", ack, 1);
    i2c_start();
    wbyte({DEV, 1'b1}, ack); chk(ack, "R4 dev ack (read)", ack, 1);
    eptr = a;
    read_body(n, "R4/R7 random/sequential data");
    i2c_stop();
  endtask

  task automatic do_cur_read(input int n, input string tag);
    logic ack;
    i2c_start();
    wbyte({DEV, 1'b1}, ack); chk(ack, "R5 dev ack (current read)", ack, 1);
    read_body(n, tag);
    i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic ack, b;
    int base;
    void'($urandom(32'h5EED_0A1B));
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 8'(i * 37 + 11);
      emem[i] = mem[i];
    end
    eptr = 8'd0;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // reset state (R5: counter starts at 0)
    chk(sda_oe == 1'b0, "R5 reset sda_oe", sda_oe, 0);
    chk(wr_valid == 1'b0, "R5 reset wr_valid", wr_valid, 0);
    chk(rd_addr == 8'd0, "R5 reset counter", rd_addr, 0);
    do_cur_read(2, "R5 current read after reset");

    // R1: foreign address is ignored
    base = wr_cnt;
    i2c_start();
    wbyte({7'h51, 1'b0}, ack); chk(!ack, "R1 mismatch nack", ack, 0);
    wbyte(8'h10, ack);         chk(!ack, "R1 later byte nack", ack, 0);
    wbyte(8'hA5, ack);         chk(!ack, "R1 data nack", ack, 0);
    i2c_stop();
    chk(wr_cnt == base, "R1 no strobe on mismatch", wr_cnt - base, 0);
    do_cur_read(1, "R1 counter untouched by mismatch");

    // R2: busy write buffer refuses the address, then polling succeeds
    wr_busy = 1'b1;
    i2c_start();
    wbyte({DEV, 1'b0}, ack); chk(!ack, "R2 busy nack", ack, 0);
    i2c_stop();
    wr_busy = 1'b0;
    i2c_start();
    wbyte({DEV, 1'b0}, ack); chk(ack, "R2 poll ack when idle", ack, 1);
    i2c_stop();

    // R3 / R5: write then current read continues after it
    do_write(8'h20, 3);
    do_cur_read(2, "R5 current read after write");
    do_cur_read(1, "R5 current read after read");

    // R6: wrap at the top
    do_write(8'hFF, 1);
    do_cur_read(2, "R6 current read wraps to 0");
    do_rand_read(8'hFD, 5);

    // R8: after master nack the line stays released
    i2c_start();
    wbyte({DEV, 1'b1}, ack); chk(ack, "R8 dev ack", ack, 1);
    read_body(1, "R8 data before nack");
    rbit(b);  chk(b == 1'b1, "R8 line released after nack", b, 1);
    rbit(b);  chk(b == 1'b1, "R8 line released (2nd clock)", b, 1);
    i2c_stop();

    // R9: STOP in the middle of a data byte
    base = wr_cnt;
    i2c_start();
    wbyte({DEV, 1'b0}, ack); wbyte(8'h40, ack);
    for (int i = 0; i < 4; i++) wbit(1'b0);
    i2c_stop();
    chk(wr_cnt == base, "R9 partial byte dropped on STOP", wr_cnt - base, 0);
    eptr = 8'h40;
    do_cur_read(1, "R9 word address kept after STOP");

    // R9: repeated START in the middle of a data byte
    base = wr_cnt;
    i2c_start();
    wbyte({DEV, 1'b0}, ack); wbyte(8'h60, ack);
    for (int i = 0; i < 3; i++) wbit(1'b1);
    i2c_start();
    wbyte({DEV, 1'b1}, ack); chk(ack, "R9 ack after restart", ack, 1);
    eptr = 8'h60;
    read_body(2, "R9 read after aborted byte");
    i2c_stop();
    chk(wr_cnt == base, "R9 partial byte dropped on START", wr_cnt - base, 0);

    // constrained random mix
    for (int t = 0; t < 30; t++) begin
      int op, n;
      logic [7:0] a;
      op = int'($urandom % 3);
      n  = 1 + int'($urandom % 6);
      a  = ($urandom % 4 == 0) ? 8'(8'd250 + $urandom % 6) : 8'($urandom);
      case (op)
        0: do_write(a, n);
        1: do_rand_read(a, n);
        default: do_cur_read(n, "R5/R7 random current read");
      endcase
    end

    chk(viol == 0, "R10 drive changed with clock high", viol, 0);
    report();
  end
endmodule